// File: doc/BRIEF.md
# Microprogram Address Sequencer with Link Register

This block chooses the control-store address of the next microinstruction on every clock of a microcoded control unit. The sequencing fields of the microinstruction now being executed arrive as decoded control bits. With them come a branch target field, a branch condition, the opcode bits of the instruction register and a result-is-zero flag from the ALU. From these inputs the block forms `next_addr` combinationally, and it registers that value into `cur_addr`, the address of the microinstruction now executing. The control store, datapath and ALU sit outside the block.

A link register of `LINK_W` bits is loaded from a data input. It serves three purposes. A branch can OR it into its target to make an indexed branch. An ALU microinstruction can jump through it. A nonzero test can branch to it. There is also an execute-one option for branches. The microinstruction at the branch target runs once, and sequencing then goes back to the address that follows the branch. A one-entry return register, loaded when such a branch fires, holds that address.

Top module: `microseq`

## Requirements
- R1: A synchronous active-high `rst` drives `next_addr` to 0 while it is asserted, sets `cur_addr` to 0 at the clock edge, clears the link register (so a link jump right after reset goes to 0) and cancels any pending execute-one return.
- R2: With no sequencing control active, `next_addr` equals `cur_addr + 1` and wraps from all ones to 0.
- R3: When `br_en` is 1, a branch goes to `br_target`. If `br_cond_en` is 0 the branch always goes. If `br_cond_en` is 1 the branch goes only when `br_cond` is 1, and otherwise the address increments.
- R4: A taken branch with `br_index` set goes to `br_target` bitwise ORed with the link register.
- R5: When `dispatch` is 1, `next_addr` equals the `opcode` input zero-extended and shifted left by `DISP_SHIFT` bits, which is 2 by default.
- R6: When `link_jump` is 1, `next_addr` equals the link register.
- R7: When `zero_test` is 1 and `alu_zero` is 0, `next_addr` equals the link register. When `alu_zero` is 1, the test has no effect.
- R8: When a taken branch has `br_exec` set, the target microinstruction executes for exactly one cycle and `next_addr` is then the branch's own address + 1, whatever that target microinstruction requests. A branch that is not taken ignores `br_exec`.
- R9: When several sources are active, the source with the higher priority wins, in this order from highest: reset, execute-one return, dispatch, link jump or nonzero test, taken branch, increment.
- R10: `link_load` writes `link_din` into the link register at the clock edge. A link jump in the same cycle uses the old value, and the new value applies from the next cycle.
- R11: At each clock edge outside reset, `cur_addr` takes the value that `next_addr` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | Current microinstruction is a branch |
| br_cond_en | input | 1 | Branch depends on `br_cond` |
| br_cond | input | 1 | Branch condition |
| br_index | input | 1 | OR the link register into the branch target |
| br_exec | input | 1 | Execute-one option on the branch |
| br_target | input | ADDR_W | Branch address field |
| dispatch | input | 1 | Opcode dispatch |
| opcode | input | OPC_W | Opcode bits from the instruction register |
| link_jump | input | 1 | Jump modifier: go to the link register |
| zero_test | input | 1 | Go to the link register if the ALU result is nonzero |
| alu_zero | input | 1 | ALU result is zero |
| link_load | input | 1 | Write `link_din` into the link register |
| link_din | input | LINK_W | Link register load data |
| next_addr | output | ADDR_W | Next microaddress |
| cur_addr | output | ADDR_W | Registered current microaddress |

## Verification
The hardest case to reach from the ports is an execute-one return that competes with other sources. The target microinstruction must itself request a dispatch, a link jump or a new execute-one branch, and the return must still win, with no second return armed. The stimulus first moves to a known address with a plain branch and then fires an execute-one branch. In the single cycle that follows, it drives every other sequencing control at once. A second sequence issues an execute-one branch whose condition is false, to show that no return is left armed.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  typedef enum logic [2:0] {
    SRC_RESET    = 3'd0,
    SRC_RETURN   = 3'd1,
    SRC_DISPATCH = 3'd2,
    SRC_LINK     = 3'd3,
    SRC_BRANCH   = 3'd4,
    SRC_INCR     = 3'd5
  } nxt_src_e;
endpackage

// File: rtl/microseq_link.sv
module microseq_link #(
  parameter int LINK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LINK_W-1:0] din,
  output logic [LINK_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= din;
  end

  // R10: loaded value appears one cycle after the load
  assert_link_load_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));
  // R1: reset clears the link register
  assert_link_reset_R1: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/microseq_ret.sv
module microseq_ret #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] ret_in,
  output logic              pending,
  output logic [ADDR_W-1:0] ret_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      ret_addr <= '0;
    end else begin
      pending <= arm;
      if (arm) ret_addr <= ret_in;
    end
  end

  // R8: a pending return lasts exactly one cycle
  assert_single_return_R8: assert property (@(posedge clk) disable iff (rst)
    pending |=> !pending);
endmodule

// File: rtl/microseq_select.sv
module microseq_select
  import microseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINK_W     = 16,
  parameter int OPC_W      = 8,
  parameter int DISP_SHIFT = 2
) (
  input  logic              rst,
  input  logic [ADDR_W-1:0] cur,
  input  logic              br_en,
  input  logic              br_cond_en,
  input  logic              br_cond,
  input  logic              br_index,
  input  logic              br_exec,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              dispatch,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              link_jump,
  input  logic              zero_test,
  input  logic              alu_zero,
  input  logic [LINK_W-1:0] link_q,
  input  logic              ret_pending,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] next_addr,
  output nxt_src_e          src,
  output logic              exec_fire
);
  function automatic logic [ADDR_W-1:0] incr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] disp_addr(input logic [OPC_W-1:0] op);
    return ADDR_W'(op) << DISP_SHIFT;
  endfunction

  function automatic logic [ADDR_W-1:0] link_addr(input logic [LINK_W-1:0] l);
    return ADDR_W'(l);
  endfunction

  function automatic logic [ADDR_W-1:0] branch_addr(
    input logic [ADDR_W-1:0] tgt, input logic idx, input logic [LINK_W-1:0] l);
    return idx ? (tgt | link_addr(l)) : tgt;
  endfunction

  logic br_taken, lnk_taken;
  assign br_taken  = br_en && (!br_cond_en || br_cond);
  assign lnk_taken = link_jump || (zero_test && !alu_zero);

  always_comb begin
    if (rst)              src = SRC_RESET;
    else if (ret_pending) src = SRC_RETURN;
    else if (dispatch)    src = SRC_DISPATCH;
    else if (lnk_taken)   src = SRC_LINK;
    else if (br_taken)    src = SRC_BRANCH;
    else                  src = SRC_INCR;
  end

  always_comb begin
    unique case (src)
      SRC_RESET:    next_addr = '0;
      SRC_RETURN:   next_addr = ret_addr;
      SRC_DISPATCH: next_addr = disp_addr(opcode);
      SRC_LINK:     next_addr = link_addr(link_q);
      SRC_BRANCH:   next_addr = branch_addr(br_target, br_index, link_q);
      default:      next_addr = incr(cur);
    endcase
  end

  assign exec_fire = (src == SRC_BRANCH) && br_exec;
endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINK_W     = 16,
  parameter int OPC_W      = 8,
  parameter int DISP_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_en,
  input  logic              br_cond_en,
  input  logic              br_cond,
  input  logic              br_index,
  input  logic              br_exec,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              dispatch,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              link_jump,
  input  logic              zero_test,
  input  logic              alu_zero,
  input  logic              link_load,
  input  logic [LINK_W-1:0] link_din,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [LINK_W-1:0] link_q;
  logic              ret_pending;
  logic [ADDR_W-1:0] ret_addr;
  logic              exec_fire;
  nxt_src_e          src;
  logic [ADDR_W-1:0] ret_in;

  assign ret_in = cur_addr + ADDR_W'(1);

  microseq_link #(.LINK_W(LINK_W)) u_link (
    .clk(clk), .rst(rst), .load(link_load), .din(link_din), .q(link_q)
  );

  microseq_ret #(.ADDR_W(ADDR_W)) u_ret (
    .clk(clk), .rst(rst), .arm(exec_fire), .ret_in(ret_in),
    .pending(ret_pending), .ret_addr(ret_addr)
  );

  microseq_select #(
    .ADDR_W(ADDR_W), .LINK_W(LINK_W), .OPC_W(OPC_W), .DISP_SHIFT(DISP_SHIFT)
  ) u_sel (
    .rst(rst), .cur(cur_addr),
    .br_en(br_en), .br_cond_en(br_cond_en), .br_cond(br_cond),
    .br_index(br_index), .br_exec(br_exec), .br_target(br_target),
    .dispatch(dispatch), .opcode(opcode),
    .link_jump(link_jump), .zero_test(zero_test), .alu_zero(alu_zero),
    .link_q(link_q), .ret_pending(ret_pending), .ret_addr(ret_addr),
    .next_addr(next_addr), .src(src), .exec_fire(exec_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_addr <= '0;
    else     cur_addr <= next_addr;
  end

  // R11: current address is the previous next address
  assert_cur_tracks_next_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cur_addr == $past(next_addr)));
  // R1: reset lands on address zero
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (cur_addr == '0));
  // R8: after an execute-one branch the return address follows the target
  assert_exec_return_R8: assert property (@(posedge clk) disable iff (rst)
    exec_fire |=> (next_addr == $past(cur_addr) + ADDR_W'(1)));
  // R9: a pending return overrides every other source
  assert_return_priority_R9: assert property (@(posedge clk) disable iff (rst)
    ret_pending |-> (src == SRC_RETURN));
endmodule

// File: tb/microseq_bench.sv
module microseq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, br_en, br_cond_en, br_cond, br_index, br_exec;
  logic dispatch, link_jump, zero_test, alu_zero, link_load;
  logic [15:0] br_target, link_din;
  logic [7:0]  opcode;
  logic [15:0] next_addr, cur_addr;

  microseq u_microseq (
    .clk(clk), .rst(rst), .br_en(br_en), .br_cond_en(br_cond_en),
    .br_cond(br_cond), .br_index(br_index), .br_exec(br_exec),
    .br_target(br_target), .dispatch(dispatch), .opcode(opcode),
    .link_jump(link_jump), .zero_test(zero_test), .alu_zero(alu_zero),
    .link_load(link_load), .link_din(link_din),
    .next_addr(next_addr), .cur_addr(cur_addr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cur, m_link, m_ret;
  logic        m_pend;
  bit          m_valid = 0;

  task automatic clr();
    rst = 0; br_en = 0; br_cond_en = 0; br_cond = 0; br_index = 0; br_exec = 0;
    dispatch = 0; link_jump = 0; zero_test = 0; alu_zero = 0; link_load = 0;
    br_target = '0; link_din = '0; opcode = '0;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one microinstruction cycle: inputs already set after a negedge
  task automatic step(string req);
    logic [15:0] exp;
    logic        btk, ltk, pend_n;
    #2;
    btk = br_en && (!br_cond_en || br_cond);
    ltk = link_jump || (zero_test && !alu_zero);
    pend_n = 0;
    if (rst) exp = 16'h0;
    else if (m_valid && m_pend) exp = m_ret;
    else if (dispatch) exp = {6'b0, opcode, 2'b00};
    else if (ltk) exp = m_link;
    else if (btk) begin
      exp = br_index ? (br_target | m_link) : br_target;
      pend_n = br_exec;
    end else exp = m_cur + 16'd1;
    check({req, " next"}, next_addr, exp);
    if (m_valid) check("R11 cur", cur_addr, m_cur);
    if (rst) begin
      m_cur = 0; m_link = 0; m_pend = 0; m_valid = 1;
    end else begin
      if (pend_n) m_ret = m_cur + 16'd1;
      m_pend = pend_n;
      if (link_load) m_link = link_din;
      m_cur = exp;
    end
    @(negedge clk);
    clr();
  endtask

  task automatic t_reset();
    rst = 1; step("R1");
    rst = 1; link_jump = 1; step("R1");
    link_jump = 1; step("R1 link cleared");
  endtask

  task automatic t_incr();
    step("R2"); step("R2");
    br_en = 1; br_target = 16'hFFFF; step("R3");
    step("R2 wrap");
    step("R2");
  endtask

  task automatic t_branch();
    br_en = 1; br_target = 16'h0040; step("R3 uncond");
    br_en = 1; br_cond_en = 1; br_cond = 0; br_target = 16'h0999; step("R3 not taken");
    br_en = 1; br_cond_en = 1; br_cond = 1; br_target = 16'h0123; step("R3 taken");
  endtask

  task automatic t_dispatch();
    dispatch = 1; opcode = 8'h3C; step("R5");
    dispatch = 1; opcode = 8'hFF; step("R5");
  endtask

  task automatic t_linkload();
    link_load = 1; link_din = 16'h0A00; link_jump = 1; step("R10 old value");
    link_jump = 1; step("R10 new value");
  endtask

  task automatic t_jump();
    link_load = 1; link_din = 16'h0B30; step("R6 load");
    link_jump = 1; step("R6");
    step("R2");
  endtask

  task automatic t_index();
    link_load = 1; link_din = 16'h0A00; step("R4 load");
    br_en = 1; br_index = 1; br_target = 16'h0015; step("R4");
    br_en = 1; br_index = 1; br_target = 16'h020F; step("R4 overlap");
  endtask

  task automatic t_ztest();
    zero_test = 1; alu_zero = 0; step("R7 nonzero");
    zero_test = 1; alu_zero = 1; step("R7 zero");
  endtask

  task automatic t_exec();
    br_en = 1; br_target = 16'h0100; step("R3");
    br_en = 1; br_exec = 1; br_target = 16'h0800; step("R8 exec");
    dispatch = 1; opcode = 8'h11; link_jump = 1; br_en = 1; br_exec = 1;
    br_target = 16'h0444; step("R8 return R9");
    step("R8 resume");
    br_en = 1; br_cond_en = 1; br_cond = 0; br_exec = 1; br_target = 16'h0900;
    step("R8 not taken");
    step("R8 no return");
    br_en = 1; br_exec = 1; br_target = 16'h0C00; step("R8 exec");
    rst = 1; step("R1 cancel");
    step("R1 no return");
  endtask

  task automatic t_prio();
    link_load = 1; link_din = 16'h0700; step("R9 load");
    dispatch = 1; opcode = 8'h05; link_jump = 1; br_en = 1; br_target = 16'h0333;
    step("R9 dispatch wins");
    zero_test = 1; alu_zero = 0; br_en = 1; br_target = 16'h0333;
    step("R9 link wins");
    br_en = 1; br_target = 16'h0333; zero_test = 1; alu_zero = 1;
    step("R9 branch wins");
  endtask

  initial begin
    clr();
    @(negedge clk);
    t_reset();
    t_incr();
    t_branch();
    t_dispatch();
    t_linkload();
    t_jump();
    t_index();
    t_ztest();
    t_exec();
    t_prio();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule